// File: doc/BRIEF.md
# Extended-Capabilities Parallel Port FIFO and Control Registers

This block is the host-side register set of an extended-capabilities parallel port. It holds an extended control register whose top three bits select the operating mode, a byte FIFO reached through a data register, a port control register carrying the transfer direction bit, a read-only configuration register that reports the transfer word size, and a status register with sticky flags. Software reaches all of it through a simple single-cycle register bus, and the block drives one interrupt line.

In test mode the host fills and drains the FIFO directly through the data register. This lets driver software find the FIFO depth and the two service thresholds. With the direction bit set, pushes raise the service flag once the fill level reaches the read threshold. With the direction bit clear, pops raise it once the free space reaches the write threshold. The flag is sticky. A mask bit in the extended control register gates it onto the interrupt line. Full-FIFO writes and empty-FIFO reads are dropped and recorded in sticky error bits.

Top module: `ecp_fifo_regs`

## Requirements
- R1: The extended control register at address 1 reads as {mode[2:0], spare[1:0], mask, full, empty}. Bits 7:2 hold what was last written there. Bits 1:0 are read-only flags. Writing 0x34 gives mode 3'b001, and 0xD4 or 0xD0 gives the test mode 3'b110.
- R2: The configuration register at address 3 always reads 0x10, where field [6:4]=3'b001 means 8-bit words. Writes to it have no effect.
- R3: ECR bit 0 is 1 exactly when the FIFO holds no byte. ECR bit 1 is 1 exactly when it holds DEPTH bytes (default 16).
- R4: The irq output is 1 exactly when the service flag (status bit 0) is 1 and the mask bit (ECR bit 2) is 0. Writing mask 1 silences irq without clearing the flag.
- R5: In test mode with the direction bit (port control register at address 2, bit 5) at 1, a FIFO push that brings the level to RD_THR or above (default 8) sets the service flag.
- R6: After reset the ECR reads 0x05, the port control register 0x00, the status register 0x00, and irq is 0.
- R7: Bytes read from the FIFO data register (address 0) leave in the order they were written. The empty flag stays 0 until the last stored byte has been read and is 1 right after that read.
- R8: In test mode with the direction bit at 0, a FIFO pop that leaves at least WR_THR free entries (default 8) sets the service flag.
- R9: Outside test mode, reads and writes of the FIFO data register neither change the FIFO contents nor set an error bit.
- R10: In test mode, a write to a full FIFO and a read from an empty FIFO are dropped. The first sets overflow (status bit 1) and the second sets underflow (status bit 2).
- R11: A write to the ECR with mode 3'b000 or 3'b001 empties the FIFO.
- R12: The status bits (address 4) are sticky. Writing 1 to a bit clears only that bit, and writing 0 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| rd_en | input | 1 | Register read strobe; a read of address 0 pops a byte |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from the address and current state |
| irq | output | 1 | Service interrupt |

## Verification
A register write takes effect at the clock edge that accepts it. That edge also updates the FIFO level, the flags, the sticky status bits and irq, so all of them are visible one cycle after the strobe. Read data is combinational, so the bench samples it in the same cycle as the read strobe, shortly after driving it on the falling edge. A FIFO read shows the head byte before the pop happens at the following rising edge. Every check is taken at a falling edge plus a small delay, after the rising edge that should have produced the result.

// File: rtl/ecp_pkg.sv
package ecp_pkg;

    localparam int REG_ADDR_W = 3;

    localparam logic [REG_ADDR_W-1:0] REG_FIFO = 3'd0;
    localparam logic [REG_ADDR_W-1:0] REG_ECR  = 3'd1;
    localparam logic [REG_ADDR_W-1:0] REG_PCTL = 3'd2;
    localparam logic [REG_ADDR_W-1:0] REG_CFG  = 3'd3;
    localparam logic [REG_ADDR_W-1:0] REG_STAT = 3'd4;

    // transfer word size code reported in config bits [6:4]
    localparam logic [2:0] WORD8_CODE = 3'b001;

    typedef enum logic [2:0] {
        MODE_STD  = 3'b000,
        MODE_BYTE = 3'b001,
        MODE_FIFO = 3'b010,
        MODE_ECP  = 3'b011,
        MODE_EPP  = 3'b100,
        MODE_RSV  = 3'b101,
        MODE_TEST = 3'b110,
        MODE_CFG  = 3'b111
    } ecp_mode_e;

    typedef struct packed {
        ecp_mode_e  mode;
        logic [1:0] spare;
        logic       mask;
        logic [7:0] pctl;
        logic       svc;
        logic       ovf;
        logic       unf;
    } ctl_state_t;

endpackage

// File: rtl/ecp_byte_fifo.sv
module ecp_byte_fifo #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic          flush,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [AW-1:0]            wr_ptr;
        logic [AW-1:0]            rd_ptr;
        logic [CW-1:0]            cnt;
    } fifo_state_t;

    localparam logic [AW-1:0] LAST_IDX  = AW'(DEPTH - 1);
    localparam logic [CW-1:0] DEPTH_CNT = CW'(DEPTH);

    fifo_state_t s_d, s_q;
    logic        push_ok, pop_ok;
    logic [DEPTH-1:0] slot_we;

    assign push_ok = push && (s_q.cnt != DEPTH_CNT);
    assign pop_ok  = pop  && (s_q.cnt != '0);

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        assign slot_we[i] = push_ok && (s_q.wr_ptr == AW'(i));
    end

    always_comb begin
        s_d = s_q;
        for (int i = 0; i < DEPTH; i++) begin
            if (slot_we[i]) s_d.mem[i] = wdata;
        end
        if (push_ok) s_d.wr_ptr = (s_q.wr_ptr == LAST_IDX) ? '0 : s_q.wr_ptr + 1'b1;
        if (pop_ok)  s_d.rd_ptr = (s_q.rd_ptr == LAST_IDX) ? '0 : s_q.rd_ptr + 1'b1;
        case ({push_ok, pop_ok})
            2'b10:   s_d.cnt = s_q.cnt + 1'b1;
            2'b01:   s_d.cnt = s_q.cnt - 1'b1;
            default: s_d.cnt = s_q.cnt;
        endcase
        if (flush) begin
            s_d.wr_ptr = '0;
            s_d.rd_ptr = '0;
            s_d.cnt    = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign head  = s_q.mem[s_q.rd_ptr];
    assign count = s_q.cnt;
    assign full  = (s_q.cnt == DEPTH_CNT);
    assign empty = (s_q.cnt == '0);

endmodule

// File: rtl/ecp_ctrl_regs.sv
module ecp_ctrl_regs
    import ecp_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int RD_THR = 8,
    parameter int WR_THR = 8,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [REG_ADDR_W-1:0] addr,
    input  logic [7:0]            wdata,
    input  logic [CW-1:0]         fifo_count,
    input  logic                  fifo_full,
    input  logic                  fifo_empty,
    output logic                  push,
    output logic                  pop,
    output logic                  flush,
    output ctl_state_t            state,
    output logic                  dir,
    output logic                  irq
);

    localparam logic [CW:0] RD_LIM   = (CW+1)'(RD_THR);
    localparam logic [CW:0] WR_LIM   = (CW+1)'(WR_THR);
    localparam logic [CW:0] DEPTH_EX = (CW+1)'(DEPTH);

    ctl_state_t s_d, s_q;
    logic       test_mode, fifo_wr, fifo_rd, ovf_evt, unf_evt, svc_set;
    logic [CW:0] lvl_after_push, free_after_pop;

    assign test_mode = (s_q.mode == MODE_TEST);
    assign dir       = s_q.pctl[5];
    assign fifo_wr   = wr_en && (addr == REG_FIFO) && test_mode;
    assign fifo_rd   = rd_en && (addr == REG_FIFO) && test_mode;
    assign push      = fifo_wr && !fifo_full;
    assign pop       = fifo_rd && !fifo_empty;
    assign ovf_evt   = fifo_wr && fifo_full;
    assign unf_evt   = fifo_rd && fifo_empty;
    assign flush     = wr_en && (addr == REG_ECR) &&
                       ((wdata[7:5] == MODE_STD) || (wdata[7:5] == MODE_BYTE));

    assign lvl_after_push = {1'b0, fifo_count} + 1'b1;
    assign free_after_pop = DEPTH_EX - ({1'b0, fifo_count} - 1'b1);

    assign svc_set = (push && dir && (lvl_after_push >= RD_LIM)) ||
                     (pop && !dir && (free_after_pop >= WR_LIM));

    always_comb begin
        s_d = s_q;
        if (wr_en && (addr == REG_ECR)) begin
            s_d.mode  = ecp_mode_e'(wdata[7:5]);
            s_d.spare = wdata[4:3];
            s_d.mask  = wdata[2];
        end
        if (wr_en && (addr == REG_PCTL)) s_d.pctl = wdata;
        if (wr_en && (addr == REG_STAT)) begin
            if (wdata[0]) s_d.svc = 1'b0;
            if (wdata[1]) s_d.ovf = 1'b0;
            if (wdata[2]) s_d.unf = 1'b0;
        end
        if (svc_set) s_d.svc = 1'b1;
        if (ovf_evt) s_d.ovf = 1'b1;
        if (unf_evt) s_d.unf = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.mask <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign state = s_q;
    assign irq   = s_q.svc && !s_q.mask;

endmodule

// File: rtl/ecp_fifo_regs.sv
module ecp_fifo_regs
    import ecp_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int RD_THR = 8,
    parameter int WR_THR = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [2:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       irq
);

    localparam int CW = $clog2(DEPTH + 1);

    logic          push, pop, flush, dir;
    logic [7:0]    head;
    logic [CW-1:0] fifo_count;
    logic          fifo_full, fifo_empty;
    ctl_state_t    cs;

    ecp_byte_fifo #(.DEPTH(DEPTH), .DW(8)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (pop),
        .flush (flush),
        .wdata (wdata),
        .head  (head),
        .count (fifo_count),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    ecp_ctrl_regs #(.DEPTH(DEPTH), .RD_THR(RD_THR), .WR_THR(WR_THR)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .addr       (addr),
        .wdata      (wdata),
        .fifo_count (fifo_count),
        .fifo_full  (fifo_full),
        .fifo_empty (fifo_empty),
        .push       (push),
        .pop        (pop),
        .flush      (flush),
        .state      (cs),
        .dir        (dir),
        .irq        (irq)
    );

    always_comb begin
        unique case (addr)
            REG_FIFO: rdata = ((cs.mode == MODE_TEST) && !fifo_empty) ? head : 8'h00;
            REG_ECR:  rdata = {cs.mode, cs.spare, cs.mask, fifo_full, fifo_empty};
            REG_PCTL: rdata = cs.pctl;
            REG_CFG:  rdata = {1'b0, WORD8_CODE, 4'b0000};
            REG_STAT: rdata = {5'b00000, cs.unf, cs.ovf, cs.svc};
            default:  rdata = 8'h00;
        endcase
    end

endmodule

// File: rtl/ecp_fifo_regs_chk.sv
module ecp_fifo_regs_chk
    import ecp_pkg::*;
#(
    parameter int RD_THR = 8,
    parameter int CW     = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          rd_en,
    input logic [2:0]    addr,
    input logic [7:0]    wdata,
    input logic          irq,
    input logic [CW-1:0] fifo_count,
    input logic          fifo_full,
    input logic          fifo_empty,
    input logic          push,
    input logic          pop,
    input logic          flush,
    input logic          dir,
    input ctl_state_t    cs
);

    // R3
    flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_full && fifo_empty));

    // R7
    pop_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !flush) |=> (fifo_count == $past(fifo_count) - 1'b1));

    // R10
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == REG_FIFO && fifo_full && !rd_en) |=> ($stable(fifo_count) && fifo_full));

    // R11
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> fifo_empty);

    // R12
    svc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs.svc && !(wr_en && addr == REG_STAT && wdata[0])) |=> cs.svc);

    // R4
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == REG_ECR && wdata[2]) |=> !irq);

    // R9
    nontest_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs.mode != MODE_TEST && !flush) |=> $stable(fifo_count));

    // R5
    rd_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && dir && !flush && (int'(fifo_count) + 1 >= RD_THR)) |=> cs.svc);

endmodule

bind ecp_fifo_regs ecp_fifo_regs_chk #(.RD_THR(RD_THR), .CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .addr       (addr),
    .wdata      (wdata),
    .irq        (irq),
    .fifo_count (fifo_count),
    .fifo_full  (fifo_full),
    .fifo_empty (fifo_empty),
    .push       (push),
    .pop        (pop),
    .flush      (flush),
    .dir        (dir),
    .cs         (cs)
);

// File: tb/ecp_fifo_regs_test.sv
`timescale 1ns/1ps
module ecp_fifo_regs_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       irq;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    ecp_fifo_regs #(.DEPTH(16), .RD_THR(8), .WR_THR(8)) uut (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .irq   (irq)
    );

    // {write(1)/check(0), addr[2:0], data-or-expected[7:0]}
    localparam int NVEC = 17;
    localparam logic [11:0] VEC [NVEC] = '{
        {1'b0, 3'd1, 8'h05}, {1'b0, 3'd3, 8'h10}, {1'b0, 3'd2, 8'h00},
        {1'b0, 3'd4, 8'h00}, {1'b1, 3'd3, 8'hFF}, {1'b0, 3'd3, 8'h10},
        {1'b1, 3'd1, 8'h34}, {1'b0, 3'd1, 8'h35}, {1'b1, 3'd0, 8'hAA},
        {1'b0, 3'd1, 8'h35}, {1'b0, 3'd4, 8'h00}, {1'b1, 3'd2, 8'h20},
        {1'b0, 3'd2, 8'h20}, {1'b1, 3'd1, 8'hD4}, {1'b0, 3'd1, 8'hD5},
        {1'b1, 3'd1, 8'hD0}, {1'b0, 3'd1, 8'hD1}
    };

    function automatic string vec_tag(int i);
        case (i)
            0, 2, 3:  return "R6";
            1, 5:     return "R2";
            9, 10:    return "R9";
            12:       return "R5";
            default:  return "R1";
        endcase
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got 0x00 expected 0x01");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R6 irq at reset
        #1 check("R6", {7'b0, irq}, 8'h00);

        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][11]) bus_wr(VEC[i][10:8], VEC[i][7:0]);
            else begin
                bus_rd(VEC[i][10:8], v);
                check(vec_tag(i), v, VEC[i][7:0]);
            end
        end

        // R5 fill with direction=1, flag from 8th byte on
        for (int i = 0; i < 16; i++) begin
            bus_wr(3'd0, 8'(i + 8'h40));
            bus_rd(3'd4, v);
            check("R5", {7'b0, v[0]}, {7'b0, (i + 1 >= 8)});
            check("R4", {7'b0, irq}, {7'b0, (i + 1 >= 8)});
        end
        bus_rd(3'd1, v);
        check("R3", v, 8'hD2);

        // R10 overflow dropped
        bus_wr(3'd0, 8'h99);
        bus_rd(3'd4, v);
        check("R10", v, 8'h03);
        bus_rd(3'd1, v);
        check("R10", v, 8'hD2);
        // R12 clear only overflow
        bus_wr(3'd4, 8'h02);
        bus_rd(3'd4, v);
        check("R12", v, 8'h01);
        bus_wr(3'd4, 8'h01);
        bus_rd(3'd4, v);
        check("R12", v, 8'h00);

        // R8 drain with direction=0
        bus_wr(3'd2, 8'h00);
        for (int k = 0; k < 16; k++) begin
            bus_rd(3'd0, v);
            check("R7", v, 8'(k + 8'h40));
            bus_rd(3'd4, v);
            check("R8", {7'b0, v[0]}, {7'b0, (k >= 7)});
            bus_rd(3'd1, v);
            check("R7", {7'b0, v[0]}, {7'b0, (k == 15)});
        end

        // R4 masking
        check("R4", {7'b0, irq}, 8'h01);
        bus_wr(3'd1, 8'hD4);
        check("R4", {7'b0, irq}, 8'h00);
        bus_rd(3'd4, v);
        check("R4", v, 8'h01);
        bus_wr(3'd1, 8'hD0);
        check("R4", {7'b0, irq}, 8'h01);

        // R10 underflow
        bus_rd(3'd0, v);
        bus_rd(3'd4, v);
        check("R10", v, 8'h05);
        bus_wr(3'd4, 8'h05);
        bus_rd(3'd4, v);
        check("R12", v, 8'h00);
        check("R4", {7'b0, irq}, 8'h00);

        // R11 flush by mode change
        bus_wr(3'd0, 8'h11);
        bus_wr(3'd0, 8'h22);
        bus_wr(3'd0, 8'h33);
        bus_rd(3'd1, v);
        check("R11", v, 8'hD0);
        bus_wr(3'd1, 8'h34);
        bus_rd(3'd1, v);
        check("R11", v, 8'h35);
        bus_wr(3'd1, 8'hD4);
        bus_rd(3'd0, v);
        bus_rd(3'd4, v);
        check("R11", v, 8'h04);

        // R6 reset mid-run
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        bus_rd(3'd1, v);
        check("R6", v, 8'h05);
        bus_rd(3'd4, v);
        check("R6", v, 8'h00);
        bus_rd(3'd2, v);
        check("R6", v, 8'h00);
        check("R6", {7'b0, irq}, 8'h00);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule